// File: doc/BRIEF.md
# Preemption Technique Cost Selector

This block decides which shader cores give way when a newly arriving kernel needs cores, and how each of them is vacated. It watches every thread-block slot of every core through a stream of per-cycle updates: block launch, retired warp instructions, loss of re-executability, and block retirement. From that state, and from a few configuration values, it estimates two costs for three ways of vacating a core. The first is flushing, which discards the work done so far and re-runs the block later. The second is switching, which saves the context and restores it later. The third is draining, which lets the resident blocks run to completion. The two costs are the latency until the core is free and the work lost.

A request names how many cores are wanted and a latency limit. For each core, the selector takes the technique with the least lost work among those whose latency fits the limit. It then hands out cores in order of increasing cost, one per cycle, each with its technique code. A pulse marks the end of the list. Cores with no resident block cost nothing and are handed out with the "none" code. A core on which no technique fits the limit still gets the fastest technique, and the output marks it as a violation.

All arithmetic is integer. The switch latency is supplied ready-computed as a cycle count, that is, context size over the core's share of memory bandwidth. IPC and CPI are whole numbers per core.

Top module: `preempt_selector`

## Requirements
- R1: After reset `req_ready` is 1, and `vic_valid` and `done` are 0. Every slot is empty, with progress 0 and not re-executable.
- R2: Slot updates use `upd_op` codes as follows. 0 launches a block and sets progress 0 and re-executable. 1 adds `upd_insts` to the progress of a resident block, saturating. 2 clears re-executability until the next launch. 3 empties the slot.
- R3: Flushing a core has latency 0 and lost work equal to the sum of resident progress. It is allowed only when every resident block on the core is re-executable.
- R4: Switching a core has latency `cfg_switch_lat` and lost work 2 × IPC × `cfg_switch_lat`.
- R5: Draining a core has a latency equal to the largest remaining count over its resident blocks, multiplied by the core's CPI. A block's remaining count is `cfg_avg_insts` minus its progress, or 0 if that would be negative. Lost work is the sum over resident blocks of (largest resident progress − block progress).
- R6: A technique fits when its latency ≤ the latched limit. Among fitting techniques the least lost work wins, and on equal lost work flush beats switch and switch beats drain. Codes: 2'b01 flush, 2'b10 switch, 2'b11 drain.
- R7: If no technique fits, the core takes switch or drain, whichever has the smaller latency (switch on a tie), and is flagged as a violation.
- R8: A core with no resident block gets code 2'b00, lost work 0 and no violation flag.
- R9: Cores are handed out without repetition. Non-violating cores come before violating ones, then in ascending lost work, then in ascending index.
- R10: A request is taken when `req_valid` and `req_ready` are both 1. The count is clamped to the number of cores. Victims appear on consecutive cycles, starting the cycle after acceptance. `done` pulses one cycle after the last victim, or one cycle after acceptance for a count of 0. `req_ready` stays 0 from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_valid | input | 1 | Slot update strobe |
| upd_core | input | 2 | Core addressed by the update |
| upd_slot | input | 1 | Slot addressed by the update |
| upd_op | input | 2 | Update kind: 0 launch, 1 step, 2 taint, 3 retire |
| upd_insts | input | 10 | Warp instructions retired (step only) |
| cfg_switch_lat | input | 24 | Precomputed context switch latency in cycles |
| cfg_avg_insts | input | 16 | Average warp instructions per thread block |
| cfg_core_ipc | input | 16 | Per-core IPC, 4 bits per core, core 0 lowest |
| cfg_core_cpi | input | 16 | Per-core CPI, 4 bits per core, core 0 lowest |
| req_valid | input | 1 | Victim request strobe |
| req_count | input | 3 | Number of cores wanted |
| req_lat_limit | input | 24 | Latency limit in cycles |
| req_ready | output | 1 | Selector idle, request may be taken |
| vic_valid | output | 1 | Victim entry strobe |
| vic_core | output | 2 | Victim core index |
| vic_tech | output | 2 | Technique code for the victim |
| vic_viol | output | 1 | Victim misses the latency limit |
| done | output | 1 | End of victim list |

## Verification
On every cycle the assertions check the slot bookkeeping: a launch resets a slot, steps never lower progress, and lost re-executability stays lost. They also check that flush is never picked for a core with a non-re-executable block, that violations carry only switch or drain, and that empty cores carry the none code. The ranking unit is checked never to pick a core already handed out, and the handshake is checked to keep `done` a single-cycle pulse with the request held off while victims flow. The cost arithmetic cannot be seen by a property. This covers the factor of two in switching, the CPI scaling and the exact latency boundary, and the bench shows these through scenarios that move a core's choice across each threshold. The complete ranking order under mixed violating and non-violating cores is also shown only by the bench's scenarios.

// File: rtl/psel_pkg.sv
package psel_pkg;
   typedef enum logic [1:0] {
      TECH_NONE   = 2'b00,
      TECH_FLUSH  = 2'b01,
      TECH_SWITCH = 2'b10,
      TECH_DRAIN  = 2'b11
   } tech_e;

   typedef enum logic [1:0] {
      OP_LAUNCH = 2'd0,
      OP_STEP   = 2'd1,
      OP_TAINT  = 2'd2,
      OP_RETIRE = 2'd3
   } upd_op_e;
endpackage

// File: rtl/psel_slot_track.sv
module psel_slot_track
   import psel_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int STEP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  upd_op_e           op,
   input  logic [STEP_W-1:0] insts,
   output logic              resident,
   output logic              idem,
   output logic [CNT_W-1:0]  prog
);
   if (STEP_W > CNT_W) begin : g_bad_step
      $error("psel_slot_track: STEP_W must not exceed CNT_W");
   end

   logic [CNT_W:0] sum;
   assign sum = {1'b0, prog} + (CNT_W+1)'(insts);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resident <= 1'b0;
         idem     <= 1'b0;
         prog     <= '0;
      end else if (hit) begin
         case (op)
            OP_LAUNCH: begin
               resident <= 1'b1;
               idem     <= 1'b1;
               prog     <= '0;
            end
            OP_STEP: if (resident) prog <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
            OP_TAINT: idem <= 1'b0;
            default: begin
               resident <= 1'b0;
               idem     <= 1'b0;
               prog     <= '0;
            end
         endcase
      end
   end

   AST_LAUNCH_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      hit && op == OP_LAUNCH |=> resident && idem && prog == '0); // R2
   AST_STEP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      hit && op == OP_STEP |=> prog >= $past(prog)); // R2
   AST_TAINT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      resident && !idem && !(hit && op == OP_LAUNCH) |=> !idem); // R2
endmodule

// File: rtl/psel_core_cost.sv
module psel_core_cost
   import psel_pkg::*;
#(
   parameter int SLOTS  = 2,
   parameter int CNT_W  = 16,
   parameter int STEP_W = 10,
   parameter int RATE_W = 4,
   parameter int LAT_W  = 24,
   parameter int OVH_W  = 32,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int PROD_W = CNT_W + RATE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_hit,
   input  logic [SLOT_W-1:0] upd_slot,
   input  upd_op_e           upd_op,
   input  logic [STEP_W-1:0] upd_insts,
   input  logic [LAT_W-1:0]  switch_lat,
   input  logic [CNT_W-1:0]  avg_insts,
   input  logic [RATE_W-1:0] ipc,
   input  logic [RATE_W-1:0] cpi,
   input  logic [LAT_W-1:0]  lat_limit,
   output tech_e             tech,
   output logic [OVH_W-1:0]  ovh,
   output logic              viol
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("psel_core_cost: SLOTS must be at least 2");
   end
   if (LAT_W < PROD_W || OVH_W < RATE_W + LAT_W + 1 || OVH_W < CNT_W + SLOT_W) begin : g_bad_w
      $error("psel_core_cost: cost widths too narrow");
   end

   logic [SLOTS-1:0] res, idem;
   logic [CNT_W-1:0] prog [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      psel_slot_track #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .hit      (upd_hit && upd_slot == SLOT_W'(s)),
         .op       (upd_op),
         .insts    (upd_insts),
         .resident (res[s]),
         .idem     (idem[s]),
         .prog     (prog[s])
      );
   end

   logic              any_res, all_idem;
   logic [CNT_W-1:0]  max_prog, max_rem, rem;
   logic [OVH_W-1:0]  fl_ovh, sw_ovh, dr_ovh;
   logic [PROD_W-1:0] dr_prod;
   logic [LAT_W-1:0]  dr_lat;

   always_comb begin
      any_res  = 1'b0;
      all_idem = 1'b1;
      fl_ovh   = '0;
      max_prog = '0;
      max_rem  = '0;
      rem      = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (res[s]) begin
            any_res  = 1'b1;
            all_idem = all_idem & idem[s];
            fl_ovh   = fl_ovh + OVH_W'(prog[s]);
            if (prog[s] > max_prog) max_prog = prog[s];
            rem = (avg_insts > prog[s]) ? avg_insts - prog[s] : '0;
            if (rem > max_rem) max_rem = rem;
         end
      end
      dr_ovh = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (res[s]) dr_ovh = dr_ovh + OVH_W'(max_prog - prog[s]);
      end
      dr_prod = PROD_W'(max_rem) * PROD_W'(cpi);
      dr_lat  = LAT_W'(dr_prod);
      sw_ovh  = (OVH_W'(ipc) * OVH_W'(switch_lat)) << 1;
   end

   logic found, sw_ok, dr_ok;
   assign sw_ok = switch_lat <= lat_limit;
   assign dr_ok = dr_lat <= lat_limit;

   always_comb begin
      tech  = TECH_NONE;
      ovh   = '0;
      viol  = 1'b0;
      found = 1'b0;
      if (any_res) begin
         if (all_idem) begin
            tech  = TECH_FLUSH;
            ovh   = fl_ovh;
            found = 1'b1;
         end
         if (sw_ok && (!found || sw_ovh < ovh)) begin
            tech  = TECH_SWITCH;
            ovh   = sw_ovh;
            found = 1'b1;
         end
         if (dr_ok && (!found || dr_ovh < ovh)) begin
            tech  = TECH_DRAIN;
            ovh   = dr_ovh;
            found = 1'b1;
         end
         if (!found) begin
            viol = 1'b1;
            if (switch_lat <= dr_lat) begin
               tech = TECH_SWITCH;
               ovh  = sw_ovh;
            end else begin
               tech = TECH_DRAIN;
               ovh  = dr_ovh;
            end
         end
      end
   end

   AST_FLUSH_NEEDS_IDEM: assert property (@(posedge clk) disable iff (!rst_n)
      tech == TECH_FLUSH |-> &(idem | ~res)); // R3
   AST_VIOL_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> (tech == TECH_SWITCH || tech == TECH_DRAIN) && !(&(idem | ~res))); // R7
   AST_EMPTY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      res == '0 |-> tech == TECH_NONE && ovh == '0 && !viol); // R8
endmodule

// File: rtl/psel_victim_rank.sv
module psel_victim_rank #(
   parameter int NUM_CORES = 4,
   parameter int OVH_W     = 32,
   localparam int CORE_W   = $clog2(NUM_CORES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CORES*OVH_W-1:0] ovh_flat,
   input  logic [NUM_CORES-1:0]       viol,
   input  logic [NUM_CORES-1:0]       taken,
   output logic [CORE_W-1:0]          pick,
   output logic                       any_free
);
   logic [OVH_W:0] key, best;

   always_comb begin
      pick     = '0;
      any_free = 1'b0;
      best     = '1;
      key      = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         key = {viol[c], ovh_flat[c*OVH_W +: OVH_W]};
         if (!taken[c] && (!any_free || key < best)) begin
            best     = key;
            pick     = CORE_W'(c);
            any_free = 1'b1;
         end
      end
   end

   AST_PICK_UNTAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      any_free |-> !taken[pick]); // R9
endmodule

// File: rtl/preempt_selector.sv
module preempt_selector
   import psel_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int SLOTS     = 2,
   parameter int CNT_W     = 16,
   parameter int STEP_W    = 10,
   parameter int RATE_W    = 4,
   parameter int LAT_W     = 24,
   parameter int OVH_W     = 32,
   localparam int CORE_W   = $clog2(NUM_CORES),
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int REQ_W    = $clog2(NUM_CORES + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        upd_valid,
   input  logic [CORE_W-1:0]           upd_core,
   input  logic [SLOT_W-1:0]           upd_slot,
   input  logic [1:0]                  upd_op,
   input  logic [STEP_W-1:0]           upd_insts,
   input  logic [LAT_W-1:0]            cfg_switch_lat,
   input  logic [CNT_W-1:0]            cfg_avg_insts,
   input  logic [NUM_CORES*RATE_W-1:0] cfg_core_ipc,
   input  logic [NUM_CORES*RATE_W-1:0] cfg_core_cpi,
   input  logic                        req_valid,
   input  logic [REQ_W-1:0]            req_count,
   input  logic [LAT_W-1:0]            req_lat_limit,
   output logic                        req_ready,
   output logic                        vic_valid,
   output logic [CORE_W-1:0]           vic_core,
   output logic [1:0]                  vic_tech,
   output logic                        vic_viol,
   output logic                        done
);
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("preempt_selector: NUM_CORES must be at least 2");
   end

   typedef enum logic {ST_IDLE, ST_BUSY} state_e;
   state_e               state_q;
   logic [REQ_W-1:0]     left_q;
   logic [LAT_W-1:0]     limit_q;
   logic [NUM_CORES-1:0] taken_q;

   tech_e                    core_tech [NUM_CORES];
   logic [NUM_CORES*OVH_W-1:0] core_ovh;
   logic [NUM_CORES-1:0]     core_viol;
   logic [CORE_W-1:0]        pick;
   logic                     any_free;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      psel_core_cost #(
         .SLOTS(SLOTS), .CNT_W(CNT_W), .STEP_W(STEP_W),
         .RATE_W(RATE_W), .LAT_W(LAT_W), .OVH_W(OVH_W)
      ) u_cost (
         .clk        (clk),
         .rst_n      (rst_n),
         .upd_hit    (upd_valid && upd_core == CORE_W'(c)),
         .upd_slot   (upd_slot),
         .upd_op     (upd_op_e'(upd_op)),
         .upd_insts  (upd_insts),
         .switch_lat (cfg_switch_lat),
         .avg_insts  (cfg_avg_insts),
         .ipc        (cfg_core_ipc[c*RATE_W +: RATE_W]),
         .cpi        (cfg_core_cpi[c*RATE_W +: RATE_W]),
         .lat_limit  (limit_q),
         .tech       (core_tech[c]),
         .ovh        (core_ovh[c*OVH_W +: OVH_W]),
         .viol       (core_viol[c])
      );
   end

   psel_victim_rank #(.NUM_CORES(NUM_CORES), .OVH_W(OVH_W)) u_rank (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovh_flat (core_ovh),
      .viol     (core_viol),
      .taken    (taken_q),
      .pick     (pick),
      .any_free (any_free)
   );

   assign req_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         left_q    <= '0;
         limit_q   <= '0;
         taken_q   <= '0;
         vic_valid <= 1'b0;
         vic_core  <= '0;
         vic_tech  <= TECH_NONE;
         vic_viol  <= 1'b0;
         done      <= 1'b0;
      end else begin
         vic_valid <= 1'b0;
         done      <= 1'b0;
         if (state_q == ST_IDLE) begin
            if (req_valid) begin
               limit_q <= req_lat_limit;
               left_q  <= (req_count > REQ_W'(NUM_CORES)) ? REQ_W'(NUM_CORES) : req_count;
               taken_q <= '0;
               state_q <= ST_BUSY;
            end
         end else if (left_q != '0 && any_free) begin
            vic_valid      <= 1'b1;
            vic_core       <= pick;
            vic_tech       <= core_tech[pick];
            vic_viol       <= core_viol[pick];
            taken_q[pick]  <= 1'b1;
            left_q         <= left_q - 1'b1;
         end else begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_LIST_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> !req_ready && !done); // R10
   AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R10
   AST_NONE_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid && vic_tech == TECH_NONE |-> !vic_viol); // R8
endmodule

// File: tb/preempt_selector_tb.sv
module preempt_selector_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic [1:0]  upd_core = '0;
   logic        upd_slot = 1'b0;
   logic [1:0]  upd_op = '0;
   logic [9:0]  upd_insts = '0;
   logic [23:0] cfg_switch_lat = 24'd100;
   logic [15:0] cfg_avg_insts = 16'd1000;
   logic [15:0] cfg_core_ipc = 16'h1111;
   logic [15:0] cfg_core_cpi = 16'h1111;
   logic        req_valid = 1'b0;
   logic [2:0]  req_count = '0;
   logic [23:0] req_lat_limit = '0;
   logic        req_ready, vic_valid, vic_viol, done;
   logic [1:0]  vic_core, vic_tech;

   localparam logic [1:0] NONE = 2'b00, FLUSH = 2'b01, SWITCH = 2'b10, DRAIN = 2'b11;
   localparam logic [1:0] LAUNCH = 2'd0, STEP = 2'd1, TAINT = 2'd2, RETIRE = 2'd3;

   preempt_selector u_dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_core(upd_core),
      .upd_slot(upd_slot), .upd_op(upd_op), .upd_insts(upd_insts),
      .cfg_switch_lat(cfg_switch_lat), .cfg_avg_insts(cfg_avg_insts),
      .cfg_core_ipc(cfg_core_ipc), .cfg_core_cpi(cfg_core_cpi),
      .req_valid(req_valid), .req_count(req_count), .req_lat_limit(req_lat_limit),
      .req_ready(req_ready), .vic_valid(vic_valid), .vic_core(vic_core),
      .vic_tech(vic_tech), .vic_viol(vic_viol), .done(done)
   );

   always #5ns clk = ~clk;

   int n_checks = 0;
   int n_fail = 0;
   int got_n;
   int got_gap;
   int got_core [8];
   int got_tech [8];
   int got_viol [8];

   task automatic chk(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic upd(int c, int s, logic [1:0] op, int n);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_core  = 2'(c);
      upd_slot  = 1'(s);
      upd_op    = op;
      upd_insts = 10'(n);
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   // Issue a request and record the victim list; got_gap counts cycles to done.
   task automatic run_req(int cnt, int lim);
      bit busy_ready = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready before request", int'(req_ready), 1);
      req_valid     = 1'b1;
      req_count     = 3'(cnt);
      req_lat_limit = 24'(lim);
      @(negedge clk);
      req_valid = 1'b0;
      got_n   = 0;
      got_gap = -1;
      for (int i = 0; i < 16; i++) begin
         if (done) begin
            got_gap = i;
            break;
         end
         if (req_ready) busy_ready = 1'b1;
         if (vic_valid && got_n < 8) begin
            got_core[got_n] = int'(vic_core);
            got_tech[got_n] = int'(vic_tech);
            got_viol[got_n] = int'(vic_viol);
            got_n++;
         end
         @(negedge clk);
      end
      chk(!busy_ready, "R10 ready held low while busy", int'(busy_ready), 0);
      chk(got_gap == got_n + 1, "R10 consecutive victims then done", got_gap, got_n + 1);
   endtask

   function automatic int tech_of(int c);
      for (int i = 0; i < got_n; i++) if (got_core[i] == c) return got_tech[i];
      return -1;
   endfunction

   function automatic int viol_of(int c);
      for (int i = 0; i < got_n; i++) if (got_core[i] == c) return got_viol[i];
      return -1;
   endfunction

   task automatic chk_order(string req, int c0, int c1, int c2, int c3);
      chk(got_n == 4, req, got_n, 4);
      chk(got_core[0] == c0 && got_core[1] == c1 && got_core[2] == c2 && got_core[3] == c3,
          req, got_core[0]*1000 + got_core[1]*100 + got_core[2]*10 + got_core[3],
          c0*1000 + c1*100 + c2*10 + c3);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk(vic_valid == 1'b0, "R1 vic_valid after reset", int'(vic_valid), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
   endtask

   task automatic t_idle;
      run_req(2, 0);
      chk(got_n == 2, "R10 two victims", got_n, 2);
      chk(got_core[0] == 0 && got_core[1] == 1, "R9 idle cores by index", got_core[1], 1);
      chk(got_tech[0] == NONE && got_tech[1] == NONE, "R8 idle core code none", got_tech[0], 0);
      chk(got_viol[0] == 0, "R8 idle core no violation", got_viol[0], 0);
      run_req(7, 0);
      chk_order("R10 count clamped to cores", 0, 1, 2, 3);
      run_req(0, 0);
      chk(got_n == 0 && got_gap == 1, "R10 zero count gives done only", got_gap, 1);
   endtask

   task automatic t_choice;
      upd(0, 0, LAUNCH, 0);
      upd(0, 1, LAUNCH, 0);
      upd(0, 0, STEP, 10);
      upd(0, 1, STEP, 20);
      run_req(4, 2000);
      chk_order("R9 busy core ranked after idle cores", 1, 2, 3, 0);
      chk(tech_of(0) == DRAIN, "R5 drain lost work 10 beats flush 30", tech_of(0), DRAIN);
      run_req(4, 990);
      chk(tech_of(0) == DRAIN, "R5 drain latency 990 fits limit 990", tech_of(0), DRAIN);
      run_req(4, 989);
      chk(tech_of(0) == FLUSH, "R3 flush when drain misses limit", tech_of(0), FLUSH);
   endtask

   task automatic t_switch;
      cfg_switch_lat = 24'd10;
      run_req(4, 500);
      chk(tech_of(0) == SWITCH, "R4 switch lost work 20 beats flush 30", tech_of(0), SWITCH);
      cfg_core_ipc = 16'h1112;
      run_req(4, 500);
      chk(tech_of(0) == FLUSH, "R4 ipc 2 makes switch cost 40", tech_of(0), FLUSH);
      cfg_core_ipc = 16'h1111;
      cfg_switch_lat = 24'd15;
      run_req(4, 500);
      chk(tech_of(0) == FLUSH, "R6 tie 30 goes to flush", tech_of(0), FLUSH);
      cfg_switch_lat = 24'd14;
      run_req(4, 500);
      chk(tech_of(0) == SWITCH, "R4 switch cost 28 below 30", tech_of(0), SWITCH);
      cfg_switch_lat = 24'd100;
   endtask

   task automatic t_taint;
      upd(0, 1, TAINT, 0);
      run_req(4, 500);
      chk(tech_of(0) == SWITCH && viol_of(0) == 0, "R2 taint forbids flush", tech_of(0), SWITCH);
      run_req(4, 50);
      chk(tech_of(0) == SWITCH, "R7 fastest technique on miss", tech_of(0), SWITCH);
      chk(viol_of(0) == 1, "R7 violation flagged", viol_of(0), 1);
   endtask

   task automatic t_rank;
      upd(1, 0, LAUNCH, 0);
      upd(1, 0, STEP, 5);
      upd(2, 0, LAUNCH, 0);
      upd(2, 0, STEP, 900);
      upd(2, 0, TAINT, 0);
      run_req(4, 500);
      chk_order("R9 ascending lost work", 2, 3, 1, 0);
      chk(got_tech[0] == DRAIN && got_tech[2] == FLUSH && got_tech[3] == SWITCH,
          "R6 mixed techniques", got_tech[0], DRAIN);
      run_req(4, 50);
      chk_order("R9 violating cores last", 3, 1, 0, 2);
      chk(tech_of(2) == SWITCH && viol_of(2) == 1, "R7 latency tie picks switch", tech_of(2), SWITCH);
      cfg_core_cpi = 16'h1311;
      run_req(4, 299);
      chk(tech_of(2) == SWITCH, "R5 cpi 3 gives drain latency 300", tech_of(2), SWITCH);
      run_req(4, 300);
      chk(tech_of(2) == DRAIN, "R5 drain fits at 300", tech_of(2), DRAIN);
      cfg_core_cpi = 16'h1111;
   endtask

   task automatic t_retire;
      upd(0, 0, RETIRE, 0);
      upd(0, 1, RETIRE, 0);
      upd(1, 0, RETIRE, 0);
      upd(2, 0, RETIRE, 0);
      run_req(4, 500);
      chk_order("R2 retired slots leave cores empty", 0, 1, 2, 3);
      chk(tech_of(0) == NONE && tech_of(2) == NONE, "R8 retired core code none", tech_of(0), NONE);
      upd(0, 0, LAUNCH, 0);
      run_req(4, 500);
      chk(tech_of(0) == FLUSH, "R2 launch restores re-executability", tech_of(0), FLUSH);
      chk(got_core[0] == 0, "R9 zero-cost tie by index", got_core[0], 0);
   endtask

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle();
      t_choice();
      t_switch();
      t_taint();
      t_rank();
      t_retire();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule